// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter made of 4-bit stages, and each stage wraps from all ones back to zero. A parameter sets how many stages are chained. Every stage has an active-low synchronous load enable, a 4-bit slice of the preset data and two active-high count enables. The first count enable is shared by all stages and gates only counting. The second enable, the trickle input, gates both counting and the stage's terminal-count flag. Each stage's terminal count feeds the trickle input of the stage above it. As a result, the whole chain behaves as one wide binary counter without a separate carry network.

An active-low clear resets every stage asynchronously and takes priority over everything else. Below the clear, the order of precedence is load, then count, then hold. The terminal-count flags and the overall carry-out are combinational from the stored state and the trickle enables. A chain built from several copies of this block can therefore use the carry-out as its own trickle input in the next cycle, or in the same cycle.

Top module: `cascade_counter`

## Requirements
- R1: Each 4-bit stage counts up in binary, and a stage holding 4'hF moves to 4'h0 on its next counting edge. The full STAGES×4-bit value wraps from all ones to zero.
- R2: When load and count are both requested on the same edge, the load wins.
- R3: While `clr_n` is low, every bit of `count_q` is zero without any clock edge, and no other input changes this.
- R4: With `clr_n` high and `load_n` low, `count_q` takes the value of `data_in` on the next rising edge, whatever `cnt_en` and `chain_en` are.
- R5: With `clr_n` and `load_n` high and both `cnt_en` and `chain_en` high, the full `count_q` value rises by exactly one on each rising edge.
- R6: With `load_n` high and either `cnt_en` or `chain_en` low, `count_q` keeps its value across the edge.
- R7: Stage i's flag `tc_vec[i]` is high exactly when that stage's slice `count_q[4i+3:4i]` is 4'hF and its trickle input is high. The trickle input is `chain_en` for stage 0 and `tc_vec[i-1]` otherwise. `cnt_en` has no effect on any flag.
- R8: `carry_out` equals the top stage's flag. It follows `chain_en` within the same cycle, with no register in the path.
- R9: On the first rising edge after `clr_n` goes high, the counter loads or counts according to its inputs, with no extra recovery cycle.
- R10: A stage above stage 0 advances only on an edge where every lower stage holds 4'hF and both enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous preset enable, active low |
| cnt_en | input | 1 | Count enable shared by all stages (parallel enable) |
| chain_en | input | 1 | Trickle enable into stage 0 |
| data_in | input | STAGES*4 | Preset value |
| count_q | output | STAGES*4 | Counter state, stage 0 in the low nibble |
| tc_vec | output | STAGES | Terminal-count flag of each stage |
| carry_out | output | 1 | Terminal count of the top stage |

## Verification
A faulty stage register shows up on `count_q` at the very next rising edge. The bench compares the output with an independent wide reference counter after every edge, so a wrong increment, a missed load or a missed hold is caught within one cycle. A fault in the trickle path shows up only when the lower stages reach all ones. For this reason the bench presets values just below each nibble boundary. It also reads `tc_vec` and `carry_out` with no clock edge between setting an enable and checking the flag, which exposes a registered or misgated flag in the same cycle.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_COUNT = 2'd1,
        MODE_LOAD  = 2'd2
    } ctr_mode_e;

    typedef struct packed {
        logic load_n;
        logic en_par;
        logic en_trk;
    } ctr_ctl_t;

    // Load outranks count; count needs both enables.
    function automatic ctr_mode_e pick_mode(ctr_ctl_t c);
        if (!c.load_n)
            return MODE_LOAD;
        else if (c.en_par && c.en_trk)
            return MODE_COUNT;
        else
            return MODE_HOLD;
    endfunction

endpackage

// File: rtl/ctr_mode_dec.sv
module ctr_mode_dec
    import ctr_pkg::*;
(
    input  ctr_ctl_t  ctl,
    output ctr_mode_e mode
);
    always_comb begin
        mode = pick_mode(ctl);
    end
endmodule

// File: rtl/ctr_term_detect.sv
module ctr_term_detect #(
    parameter int W = 4
) (
    input  logic [W-1:0] state,
    input  logic         trickle,
    output logic         term
);
    localparam logic [W-1:0] TOP_VAL = '1;

    always_comb begin
        term = trickle && (state == TOP_VAL);
    end
endmodule

// File: rtl/ctr_stage.sv
module ctr_stage
    import ctr_pkg::*;
#(
    parameter int W = ctr_pkg::NIB_W
) (
    input  logic         clk,
    input  logic         clr_n,
    input  ctr_ctl_t     ctl,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         tc
);
    localparam logic [W-1:0] ONE = W'(1);

    ctr_mode_e    mode;
    logic [W-1:0] q_next;

    ctr_mode_dec u_dec (
        .ctl  (ctl),
        .mode (mode)
    );

    always_comb begin
        unique case (mode)
            MODE_LOAD:  q_next = din;
            MODE_COUNT: q_next = q + ONE;
            default:    q_next = q;
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
            q <= '0;
        else
            q <= q_next;
    end

    ctr_term_detect #(.W(W)) u_term (
        .state   (q),
        .trickle (ctl.en_trk),
        .term    (tc)
    );
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
    import ctr_pkg::*;
#(
    parameter int STAGES = 3,
    parameter int W      = ctr_pkg::NIB_W
) (
    input  logic                  clk,
    input  logic                  clr_n,
    input  logic                  load_n,
    input  logic                  cnt_en,
    input  logic                  chain_en,
    input  logic [STAGES*W-1:0]   data_in,
    output logic [STAGES*W-1:0]   count_q,
    output logic [STAGES-1:0]     tc_vec,
    output logic                  carry_out
);
    localparam int TOTAL_W = STAGES * W;

    logic [STAGES:0] trk;

    assign trk[0] = chain_en;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        ctr_ctl_t ctl;

        always_comb begin
            ctl.load_n = load_n;
            ctl.en_par = cnt_en;
            ctl.en_trk = trk[i];
        end

        ctr_stage #(.W(W)) u_stage (
            .clk   (clk),
            .clr_n (clr_n),
            .ctl   (ctl),
            .din   (data_in[i*W +: W]),
            .q     (count_q[i*W +: W]),
            .tc    (tc_vec[i])
        );

        assign trk[i+1] = tc_vec[i];
    end

    assign carry_out = trk[STAGES];

    logic unused_w;
    assign unused_w = (TOTAL_W == 0);
endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
    parameter int STAGES = 3,
    parameter int W      = 4
) (
    input logic                clk,
    input logic                clr_n,
    input logic                load_n,
    input logic                cnt_en,
    input logic                chain_en,
    input logic [STAGES*W-1:0] data_in,
    input logic [STAGES*W-1:0] count_q,
    input logic [STAGES-1:0]   tc_vec,
    input logic                carry_out
);
    localparam logic [STAGES*W-1:0] ONE_T = (STAGES*W)'(1);
    localparam logic [W-1:0]        NIB_TOP = '1;

    // R3: clear forces zero
    a_r3_clear_zero: assert property (@(posedge clk)
        !clr_n |-> (count_q == '0));

    // R4 / R2: load captures data regardless of enables
    a_r4_load_capture: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> (count_q == $past(data_in)));

    // R5 / R1: increment with wrap
    a_r5_count_step: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && cnt_en && chain_en) |=> (count_q == $past(count_q) + ONE_T));

    // R6: hold when an enable is low
    a_r6_hold: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(cnt_en && chain_en)) |=> $stable(count_q));

    // R8: carry needs the external trickle and an all-ones count
    a_r8_carry_needs_chain: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out |-> (chain_en && (count_q == '1)));

    for (genvar i = 0; i < STAGES; i++) begin : g_chk
        // R7: a flag implies its slice is at the top value
        a_r7_flag_slice: assert property (@(posedge clk) disable iff (!clr_n)
            tc_vec[i] |-> (count_q[i*W +: W] == NIB_TOP));
        if (i > 0) begin : g_up
            // R10: an upper slice moves only when the one below carries
            a_r10_upper_moves: assert property (@(posedge clk) disable iff (!clr_n)
                (load_n && !tc_vec[i-1]) |=> $stable(count_q[i*W +: W]));
        end
    end
endmodule

bind cascade_counter cascade_counter_chk #(.STAGES(STAGES), .W(W)) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .load_n    (load_n),
    .cnt_en    (cnt_en),
    .chain_en  (chain_en),
    .data_in   (data_in),
    .count_q   (count_q),
    .tc_vec    (tc_vec),
    .carry_out (carry_out)
);

// File: tb/tb_cascade_counter.sv
module tb_cascade_counter;
    localparam int STAGES = 3;
    localparam int W      = 4;
    localparam int TW     = STAGES * W;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              clr_n, load_n, cnt_en, chain_en;
    logic [TW-1:0]     data_in, count_q, model;
    logic [STAGES-1:0] tc_vec;
    logic              carry_out;
    int errors = 0;
    int checks = 0;
    bit done = 0;

    cascade_counter #(.STAGES(STAGES), .W(W)) dut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
        .chain_en(chain_en), .data_in(data_in), .count_q(count_q),
        .tc_vec(tc_vec), .carry_out(carry_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [STAGES-1:0] exp_tc(input logic [TW-1:0] v, input logic te);
        logic [STAGES-1:0] r;
        logic t;
        t = te;
        for (int i = 0; i < STAGES; i++) begin
            r[i] = t && (v[i*W +: W] == {W{1'b1}});
            t = r[i];
        end
        return r;
    endfunction

    // One clocked step: drive at falling edge, check just after rising edge.
    task automatic step(input logic l, input logic ce, input logic te,
                        input logic [TW-1:0] d, input string req);
        @(negedge clk);
        load_n = l; cnt_en = ce; chain_en = te; data_in = d;
        @(posedge clk);
        if (!l) model = d;
        else if (ce && te) model = model + 1'b1;
        #2;
        check(req, count_q, model);
    endtask

    task automatic t_reset;
        clr_n = 0; load_n = 1; cnt_en = 1; chain_en = 1; data_in = '0;
        model = '0;
        repeat (3) @(posedge clk);
        #2;
        check("R3 reset count", count_q, '0);
        check("R3 reset flags", tc_vec, '0);
        @(negedge clk);
        clr_n = 1;
        @(posedge clk);
        model = model + 1'b1;
        #2;
        check("R9 first edge counts", count_q, model);
    endtask

    task automatic t_count_run;
        step(0, 1, 1, 12'h005, "R4 load");
        for (int i = 0; i < 20; i++) step(1, 1, 1, 12'h000, "R5 increment");
    endtask

    task automatic t_chain_boundary;
        step(0, 0, 0, 12'h0FE, "R4 load enables low");
        step(1, 1, 1, 12'h000, "R10 below boundary");
        step(1, 1, 1, 12'h000, "R10 two stages advance");
        check("R10 value 100", count_q, 12'h100);
        step(0, 1, 1, 12'h1EF, "R4 load");
        step(1, 1, 1, 12'h000, "R10 middle stage only");
        check("R10 value 1F0", count_q, 12'h1F0);
    endtask

    task automatic t_wrap_and_flags;
        step(0, 1, 1, 12'hFFE, "R4 load near top");
        step(1, 1, 1, 12'h000, "R1 reach top");
        @(negedge clk); #1;
        check("R8 carry at top", carry_out, 1'b1);
        check("R7 all flags", tc_vec, 3'b111);
        chain_en = 0; #1;
        check("R8 carry follows trickle", carry_out, 1'b0);
        check("R7 flags drop", tc_vec, 3'b000);
        chain_en = 1; cnt_en = 0; #1;
        check("R7 cnt_en no effect", tc_vec, 3'b111);
        step(1, 1, 1, 12'h000, "R1 wrap to zero");
        check("R1 zero", count_q, 12'h000);
        step(0, 0, 1, 12'h0FF, "R4 load");
        #1;
        check("R7 partial flags", tc_vec, 3'b011);
        check("R8 no carry", carry_out, 1'b0);
    endtask

    task automatic t_hold_and_priority;
        step(0, 1, 1, 12'h3A7, "R2 load over count");
        step(1, 0, 1, 12'hFFF, "R6 hold parallel low");
        step(1, 1, 0, 12'hFFF, "R6 hold trickle low");
        step(1, 0, 0, 12'hFFF, "R6 hold both low");
        check("R6 value kept", count_q, 12'h3A7);
        step(0, 0, 0, 12'h111, "R4 load with enables low");
    endtask

    task automatic t_async_clear;
        step(1, 1, 1, 12'h000, "R5 before clear");
        @(negedge clk);
        #2 clr_n = 0;
        #1;
        model = '0;
        check("R3 async clear no clock", count_q, 12'h000);
        @(negedge clk);
        load_n = 0; data_in = 12'h9C2;
        @(posedge clk); #2;
        check("R3 clear beats load", count_q, 12'h000);
        @(negedge clk);
        clr_n = 1;
        @(posedge clk);
        model = 12'h9C2;
        #2;
        check("R9 first edge loads", count_q, model);
    endtask

    task automatic t_random;
        for (int i = 0; i < 300; i++) begin
            logic [TW-1:0] d;
            d = TW'($urandom);
            if ((i % 7) == 0) d[7:0] = 8'hFE;
            step(($urandom % 8) != 0, ($urandom % 4) != 0, ($urandom % 5) != 0,
                 d, "R5 mixed sequence");
            #1;
            check("R7 flags mixed", tc_vec, exp_tc(model, chain_en));
        end
    endtask

    initial begin
        t_reset();
        t_count_run();
        t_chain_boundary();
        t_wrap_and_flags();
        t_hold_and_priority();
        t_async_clear();
        t_random();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule